// File: doc/BRIEF.md
# Preloadable Timer and Event Counter

This block is a 16-bit up-counter with a reload value, driven by an 8-bit register port. It runs in one of three modes. In event mode it counts edges of an external input. In timer mode it counts a power-of-two division of the system clock. In pulse-width mode it measures how long the external input stays at one level. When the count passes all-ones, the counter takes the reload value, emits a one-cycle interrupt pulse and toggles a divided-frequency output.

Software reaches the 16-bit quantities through a shared low-byte holding buffer. A write to the high-byte address commits the buffer and the new byte together as one reload value. A read of the high-byte address captures the low byte of the counter into the buffer, so the two halves that are read belong to the same count. Pulse-width mode is one-shot. It arms when enabled, starts counting on the selected edge, stops on the opposite edge, and then clears its own enable bit.

The pulse-width sequencer has three named states. PW_IDLE moves to PW_ARMED when pulse mode is enabled. PW_ARMED moves to PW_MEASURE on the start edge, and returns to PW_IDLE if the enable is dropped. PW_MEASURE returns to PW_IDLE on the return edge, which is the completion that clears the enable, or when the enable is dropped.

Top module: `tmr_event_counter`

## Requirements
- R1: After reset the counter, reload value, holding buffer and control register are all zero, and both ovf_irq and pfd_out are low.
- R2: A write to address 0 (low byte) only stores the byte in the holding buffer. The counter and the reload value are unchanged.
- R3: A write to address 1 (high byte) sets the reload value to {written byte, holding buffer}. While the enable bit is 0 the same value is also loaded into the counter. While the enable bit is 0 the counter never moves otherwise.
- R4: While the enable bit is 1, a high-byte write changes only the reload value. The counter keeps counting, and the new reload value is used at the next overflow.
- R5: A read of address 1 returns counter bits 15:8 and copies counter bits 7:0 into the holding buffer. A read of address 0 returns the buffer. The counter does not advance in the cycle of a high-byte read.
- R6: The control register is at address 2, with this layout:
  - bits 7:6 select the mode: 00 stopped, 01 event, 10 timer, 11 pulse-width.
  - bit 4 is the enable.
  - bit 3 selects the edge: 1 for rising, 0 for falling.
  - bits 2:0 are the prescale select N.
  - bit 5 always reads 0.
- R7: In timer mode with the enable set, the counter advances once every 2^N clock cycles.
- R8: In event mode with the enable set, the counter advances once for each selected edge of ext_in. ext_in passes through a two-flop synchroniser first.
- R9: An advance from 0xFFFF loads the reload value. In the next cycle ovf_irq is high for that one cycle and pfd_out has toggled. pfd_out changes at no other time.
- R10: In pulse-width mode the enable only arms the block. Counting on the prescaled clock starts at the selected edge and stops at the opposite edge. At that stop the enable bit clears itself. With N=0 the result equals the pulse width in clock cycles.
- R11: After a measurement the result is held, and later edges have no effect until software sets the enable again. The next measurement then adds to the held count.
- R12: With mode 00 the counter never advances, even with the enable set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Register select: 0 low byte, 1 high byte, 2 control |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the same cycle as bus_rd |
| ext_in | input | 1 | External event or pulse input, asynchronous |
| ovf_irq | output | 1 | One-cycle overflow pulse |
| pfd_out | output | 1 | Divided-frequency output, toggles on each overflow |

## Verification
A register write takes effect at the first clock edge while its strobe is high. The counter first advances at the edge after an enable write, and it also advances at the edge where a disabling write lands. A run between an enable write and a disable write separated by K idle cycles therefore yields K+1 timer ticks, and the bench stops the counter before reading it so that every expected value is exact. ext_in changes reach the counter at the third edge after they are applied. A pulse of L cycles measured with N=0 yields exactly L, with the stop seen three edges after the falling input. The bench leaves several idle cycles after each input change. Read data is combinational, so the bench samples it one nanosecond after setting the strobe, and its scoreboard monitor compares queued expectations at later clock edges.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    typedef enum logic [1:0] {
        MODE_STOP  = 2'b00,
        MODE_EVENT = 2'b01,
        MODE_TIMER = 2'b10,
        MODE_PULSE = 2'b11
    } tmr_mode_e;

    typedef enum logic [1:0] {
        PW_IDLE,
        PW_ARMED,
        PW_MEASURE
    } pw_state_e;

    localparam logic [1:0] ADDR_LO   = 2'd0;
    localparam logic [1:0] ADDR_HI   = 2'd1;
    localparam logic [1:0] ADDR_CTRL = 2'd2;
endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    input  logic rise_sel,
    output logic start_edge,
    output logic end_edge
);
    logic [STAGES:0] sync_q;
    logic            level, prev, rise, fall;

    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-1:0], async_in};
    end

    assign level      = sync_q[STAGES-1];
    assign prev       = sync_q[STAGES];
    assign rise       = level & ~prev;
    assign fall       = ~level & prev;
    assign start_edge = rise_sel ? rise : fall;
    assign end_edge   = rise_sel ? fall : rise;
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int PSC_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PSC_W-1:0] sel,
    output logic             tick
);
    localparam int DIV_W = (1 << PSC_W) - 1;

    logic [DIV_W-1:0] div_q;
    logic [DIV_W:0]   span, span_m1;
    logic [DIV_W-1:0] mask;

    always_ff @(posedge clk) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_q + 1'b1;
    end

    assign span    = (DIV_W+1)'(1) << sel;
    assign span_m1 = span - (DIV_W+1)'(1);
    assign mask    = span_m1[DIV_W-1:0];
    assign tick    = ((div_q & mask) == mask);
endmodule

// File: rtl/tmr_pw_fsm.sv
module tmr_pw_fsm
    import tmr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic start_edge,
    input  logic end_edge,
    input  logic tick,
    output logic count_en,
    output logic done
);
    pw_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PW_IDLE:    if (arm) state_d = PW_ARMED;
            PW_ARMED:   if (!arm) state_d = PW_IDLE;
                        else if (start_edge) state_d = PW_MEASURE;
            PW_MEASURE: if (!arm || end_edge) state_d = PW_IDLE;
            default:    state_d = PW_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PW_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        count_en = 1'b0;
        done     = 1'b0;
        unique case (state_q)
            PW_MEASURE: begin
                count_en = arm && tick;
                done     = arm && end_edge;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/tmr_event_counter.sv
module tmr_event_counter
    import tmr_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int PSC_W       = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              ext_in,
    output logic              ovf_irq,
    output logic              pfd_out
);
    localparam int CNT_W = 2 * DATA_W;

    logic [CNT_W-1:0]  cnt_q, preload_q;
    logic [DATA_W-1:0] hold_q;
    tmr_mode_e         mode_q;
    logic              en_q, edge_q;
    logic [PSC_W-1:0]  psc_q;
    logic              irq_q, pfd_q;

    logic wr_lo, wr_hi, wr_ctrl, rd_hi;
    logic tick, start_edge, end_edge, pw_cnt, pw_done;
    logic advance, ovf, load_now;

    assign wr_lo   = bus_wr && (bus_addr == ADDR_LO);
    assign wr_hi   = bus_wr && (bus_addr == ADDR_HI);
    assign wr_ctrl = bus_wr && (bus_addr == ADDR_CTRL);
    assign rd_hi   = bus_rd && (bus_addr == ADDR_HI);

    tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .async_in   (ext_in),
        .rise_sel   (edge_q),
        .start_edge (start_edge),
        .end_edge   (end_edge)
    );

    tmr_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (psc_q),
        .tick  (tick)
    );

    tmr_pw_fsm u_pw (
        .clk        (clk),
        .rst_n      (rst_n),
        .arm        (en_q && (mode_q == MODE_PULSE)),
        .start_edge (start_edge),
        .end_edge   (end_edge),
        .tick       (tick),
        .count_en   (pw_cnt),
        .done       (pw_done)
    );

    always_comb begin
        advance = 1'b0;
        unique case (mode_q)
            MODE_EVENT: advance = start_edge;
            MODE_TIMER: advance = tick;
            MODE_PULSE: advance = pw_cnt;
            default:    advance = 1'b0;
        endcase
        advance = advance && en_q && !rd_hi;
    end

    assign load_now = wr_hi && !en_q;
    assign ovf      = advance && (&cnt_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            preload_q <= '0;
            hold_q    <= '0;
        end else begin
            if (wr_lo)      hold_q <= bus_wdata;
            else if (rd_hi) hold_q <= cnt_q[DATA_W-1:0];
            if (wr_hi) preload_q <= {bus_wdata, hold_q};
            if (load_now)     cnt_q <= {bus_wdata, hold_q};
            else if (ovf)     cnt_q <= preload_q;
            else if (advance) cnt_q <= cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_STOP;
            en_q   <= 1'b0;
            edge_q <= 1'b0;
            psc_q  <= '0;
        end else if (wr_ctrl) begin
            mode_q <= tmr_mode_e'(bus_wdata[7:6]);
            en_q   <= bus_wdata[4];
            edge_q <= bus_wdata[3];
            psc_q  <= bus_wdata[PSC_W-1:0];
        end else if (pw_done) begin
            en_q   <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
            pfd_q <= 1'b0;
        end else begin
            irq_q <= ovf;
            pfd_q <= pfd_q ^ ovf;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            unique case (bus_addr)
                ADDR_LO:   bus_rdata = hold_q;
                ADDR_HI:   bus_rdata = cnt_q[CNT_W-1:DATA_W];
                ADDR_CTRL: begin
                    bus_rdata[7:6]       = mode_q;
                    bus_rdata[4]         = en_q;
                    bus_rdata[3]         = edge_q;
                    bus_rdata[PSC_W-1:0] = psc_q;
                end
                default:   bus_rdata = '0;
            endcase
        end
    end

    assign ovf_irq = irq_q;
    assign pfd_out = pfd_q;
endmodule

// File: rtl/tmr_event_counter_chk.sv
module tmr_event_counter_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [1:0]  addr,
    input logic        wr,
    input logic        rd,
    input logic [15:0] cnt,
    input logic [15:0] preload,
    input logic [1:0]  mode,
    input logic        en,
    input logic        irq,
    input logic        pfd
);
    AST_LO_WRITE_KEEPS_PRELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == 2'd0) |=> $stable(preload)); // R2
    AST_STOPPED_COUNTER_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !(wr && addr == 2'd1)) |=> $stable(cnt)); // R3
    AST_HI_READ_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !wr && addr == 2'd1) |=> $stable(cnt)); // R5
    AST_IRQ_TOGGLES_PFD: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (pfd != $past(pfd))); // R9
    AST_PFD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !irq |-> $stable(pfd)); // R9
    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(en)); // R9
    AST_SELF_CLEAR_IN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(en) && !$past(wr && addr == 2'd2)) |-> ($past(mode) == 2'b11)); // R10
    AST_STOP_MODE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00 && !(wr && addr == 2'd1)) |=> $stable(cnt)); // R12
endmodule

bind tmr_event_counter tmr_event_counter_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (bus_addr),
    .wr      (bus_wr),
    .rd      (bus_rd),
    .cnt     (cnt_q),
    .preload (preload_q),
    .mode    (mode_q),
    .en      (en_q),
    .irq     (irq_q),
    .pfd     (pfd_q)
);

// File: tb/tb_tmr_event_counter.sv
module tb_tmr_event_counter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       ext_in = 1'b0;
    logic       ovf_irq, pfd_out;

    int total = 0, failed = 0, irq_seen = 0;
    bit done = 1'b0;

    typedef struct {
        string       tag;
        logic [15:0] exp;
        logic [15:0] act;
    } item_t;
    item_t sb_q[$];

    always #2 clk = ~clk;

    tmr_event_counter dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ext_in(ext_in), .ovf_irq(ovf_irq), .pfd_out(pfd_out)
    );

    always @(negedge clk) if (rst_n && ovf_irq) irq_seen++;

    // monitor: pops queued items and compares
    initial begin
        forever begin
            @(posedge clk);
            while (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                total++;
                if (it.act !== it.exp) begin
                    failed++;
                    $display("FAIL %s actual=%h expected=%h", it.tag, it.act, it.exp);
                end
            end
        end
    end

    task automatic push(input string tag, input logic [15:0] exp, input logic [15:0] act);
        item_t it;
        it.tag = tag; it.exp = exp; it.act = act;
        sb_q.push_back(it);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic load16(input logic [15:0] v);
        wr(2'd0, v[7:0]);
        wr(2'd1, v[15:8]);
    endtask

    task automatic rd16(output logic [15:0] v);
        bus_rd = 1'b1; bus_addr = 2'd1;
        #1 v[15:8] = bus_rdata;
        @(negedge clk);
        bus_addr = 2'd0;
        #1 v[7:0] = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic rd_ctrl(output logic [7:0] v);
        bus_rd = 1'b1; bus_addr = 2'd2;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic check16(input string tag, input logic [15:0] exp);
        logic [15:0] v;
        rd16(v);
        push(tag, exp, v);
    endtask

    task automatic check_ctrl(input string tag, input logic [7:0] exp);
        logic [7:0] v;
        rd_ctrl(v);
        push(tag, {8'h00, exp}, {8'h00, v});
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic report;
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; failed++;
            $display("FAIL watchdog actual=hung expected=finished");
            report();
        end
    end

    initial begin
        logic [15:0] v;
        int base;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check_ctrl("R1 ctrl", 8'h00);
        check16("R1 counter", 16'h0000);
        push("R1 pfd", 16'h0000, {15'd0, pfd_out});

        // R3 stopped write loads counter
        load16(16'h1234);
        check16("R3 load", 16'h1234);

        // R2 low write only buffers
        wr(2'd0, 8'hAA);
        check16("R2 low write", 16'h1234);

        // R6 layout, bit5 reads 0
        wr(2'd2, 8'h2F);
        check_ctrl("R6 readback", 8'h0F);

        // R12 stopped mode
        load16(16'h0200);
        wr(2'd2, 8'h10); idle(6); wr(2'd2, 8'h00);
        check16("R12 mode00", 16'h0200);

        // R7 timer N=0: K=9 idle -> 10 ticks
        load16(16'h0100);
        wr(2'd2, 8'h90); idle(9); wr(2'd2, 8'h00);
        check16("R7 timer N0", 16'h010A);

        // R7 timer N=2: 40 edges -> 10 ticks
        load16(16'h0000);
        wr(2'd2, 8'h92); idle(39); wr(2'd2, 8'h00);
        check16("R7 timer N2", 16'h000A);

        // R5 high read freezes for one cycle
        load16(16'h0000);
        wr(2'd2, 8'h90);
        rd16(v);
        push("R5 coherent read", 16'h0000, v);
        wr(2'd2, 8'h00);
        check16("R5 freeze", 16'h0002);

        // R4 / R9 running preload write and overflow
        load16(16'hFFFD);
        base = irq_seen;
        wr(2'd2, 8'h90);
        wr(2'd0, 8'h00);
        wr(2'd1, 8'h05);
        wr(2'd2, 8'h00);
        check16("R4 reload", 16'h0500);
        push("R9 irq count", 16'd1, 16'(irq_seen - base));
        push("R9 pfd", 16'h0001, {15'd0, pfd_out});

        // R8 rising edges: 3 rises, 2 falls
        load16(16'h0000);
        wr(2'd2, 8'h58);
        ext_in = 1; idle(4); ext_in = 0; idle(4); ext_in = 1; idle(4);
        ext_in = 0; idle(4); ext_in = 1; idle(4);
        wr(2'd2, 8'h00);
        ext_in = 0; idle(4);
        check16("R8 rising", 16'h0003);

        // R8 falling edges
        load16(16'h0000);
        wr(2'd2, 8'h50);
        ext_in = 1; idle(4); ext_in = 0; idle(4); ext_in = 1; idle(4);
        ext_in = 0; idle(4); ext_in = 1; idle(4);
        wr(2'd2, 8'h00);
        ext_in = 0; idle(4);
        check16("R8 falling", 16'h0002);

        // R10 pulse width 10 cycles
        load16(16'h0000);
        wr(2'd2, 8'hD8); idle(5);
        ext_in = 1; idle(10); ext_in = 0; idle(6);
        check_ctrl("R10 enable cleared", 8'hC8);
        check16("R10 width", 16'h000A);

        // R11 held result, then re-arm
        ext_in = 1; idle(5); ext_in = 0; idle(5);
        check16("R11 held", 16'h000A);
        wr(2'd2, 8'hD8); idle(3);
        ext_in = 1; idle(4); ext_in = 0; idle(6);
        check16("R11 rearm", 16'h000E);

        idle(3);
        done = 1'b1;
        report();
    end
endmodule